// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block gathers seven interrupt conditions of a serial port into one interrupt request and a 6-bit identification code. The code names the highest-priority enabled source that is pending. Some sources are latched events and some are live levels. Each latched event keeps its own flag until its clear rule fires. Host accesses reach the block as single-cycle strobes: a read of the identification register, a read of line status, a read of modem status, a read of receive holding, and a write of transmit holding. The block has no bus decoding, FIFOs or character matching. Those neighbours supply event pulses and level inputs.

A six-bit enable vector masks each source without discarding latched events. The low four enable bits choose the mode. If any of them is set, the block runs in interrupt mode and drives the request. If all four are clear, the block is polled: the request stays low and the code still reports the pending source.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source pending, the code is 6'b000001 (bit 0 set means nothing pending) and `irq_o` is 0.
- R2: Line status has the highest priority and code 6'b000110. It is pending while a latched overrun is held or while `rx_err_lvl_i` is high. An overrun is cleared only by `lsr_rd_i`.
- R3: A receive timeout event latches the code 6'b001100, which `rhr_rd_i` clears. When receive data is also available, the timeout is reported first.
- R4: Receive data available uses code 6'b000100 and follows the `rx_trig_lvl_i` level directly.
- R5: A transmit holding event latches code 6'b000010. It clears on `thr_wr_i`, or on `id_rd_i` in a cycle when the code shows 6'b000010.
- R6: A modem status change latches code 6'b000000, which only `msr_rd_i` clears.
- R7: Code 6'b010000 reports an Xoff match or a special-character match. An Xoff cause clears only on `xon_evt_i`. A special cause clears only on an identification read that returns 6'b010000.
- R8: A low-to-high transition on either flow pin (`flow_pins_n_i` bit 0 or bit 1) latches code 6'b100000. It clears on an identification read that returns that code.
- R9: An identification read clears only the source whose code was shown during that read. Lower-priority flags stay pending.
- R10: The enable bits map as follows: bit 0 covers receive data and timeout, bit 1 transmit holding, bit 2 line status, bit 3 modem, bit 4 Xoff/special, and bit 5 the flow pins. A masked source still latches and appears once it is enabled.
- R11: With `en_i[3:0]` all zero, `irq_o` stays 0 while the code keeps reporting enabled pending sources.
- R12: If a set event and a clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R13: A latched event shows at the outputs after the clock edge that samples it. `irq_o` is combinational from the enabled flags, is high only when the code's bit 0 is 0, and the code is always one of the eight listed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 6 | Per-source enable vector (map in R10) |
| flow_pins_n_i | input | 2 | Active-low flow control pin levels (bit 0 clear-to-send, bit 1 request-to-send) |
| rx_err_lvl_i | input | 1 | A character with a framing, parity or break error is still in the receive FIFO |
| rx_trig_lvl_i | input | 1 | Receive data is available at or above the trigger level |
| ovr_evt_i | input | 1 | Overrun event pulse |
| tmo_evt_i | input | 1 | Receive timeout event pulse |
| txh_evt_i | input | 1 | Transmit holding space event pulse |
| msr_evt_i | input | 1 | Modem status change pulse |
| xoff_evt_i | input | 1 | Xoff character detected |
| xon_evt_i | input | 1 | Xon character detected |
| spec_evt_i | input | 1 | Special character detected |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| msr_rd_i | input | 1 | Modem status register read strobe |
| id_rd_i | input | 1 | Identification register read strobe |
| irq_o | output | 1 | Active-high interrupt request |
| id_code_o | output | 6 | Identification code of the top pending source |

## Verification
The level inputs for line errors and receive data pass straight to the code and the request in the same cycle. Every pulse, read and write strobe takes effect at the first rising edge after it is driven, and the bench checks the result one cycle later. For each table step, the bench drives inputs on the falling edge, lets one rising edge pass, and compares the code and request on the next falling edge. The clear-on-identification-read cases rely on the code being settled before the strobe's edge, so each step's expected value comes from the code shown in the step before it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int CODE_W  = 6;
   localparam int NUM_SRC = 7;

   // priority slots, slot 0 is highest
   localparam int SLOT_LSR = 0;
   localparam int SLOT_TMO = 1;
   localparam int SLOT_RXD = 2;
   localparam int SLOT_THR = 3;
   localparam int SLOT_MSR = 4;
   localparam int SLOT_XOF = 5;
   localparam int SLOT_FLW = 6;

   localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

   function automatic logic [CODE_W-1:0] src_code(int slot);
      case (slot)
         SLOT_LSR: return 6'b000110;
         SLOT_TMO: return 6'b001100;
         SLOT_RXD: return 6'b000100;
         SLOT_THR: return 6'b000010;
         SLOT_MSR: return 6'b000000;
         SLOT_XOF: return 6'b010000;
         default:  return 6'b100000;
      endcase
   endfunction

   // which enable bit governs each slot
   function automatic int src_en_bit(int slot);
      case (slot)
         SLOT_LSR: return 2;
         SLOT_TMO: return 0;
         SLOT_RXD: return 0;
         SLOT_THR: return 1;
         SLOT_MSR: return 3;
         SLOT_XOF: return 4;
         default:  return 5;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_i | (flag_q & ~clr_i);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= ~clr_i & (flag_q | set_i);
         end
      end
   endgenerate

   assign flag_o = flag_q;

endmodule

// File: rtl/uart_irq_edge.sv
module uart_irq_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pins_n_i,
   output logic         rise_o
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= pins_n_i;
   end

   // inactive-high transition on any pin
   assign rise_o = |(pins_n_i & ~prev_q);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter int N = uart_irq_pkg::NUM_SRC,
   parameter int W = uart_irq_pkg::CODE_W
) (
   input  logic [N-1:0] pend_i,
   output logic [N-1:0] sel_o,
   output logic         any_o,
   output logic [W-1:0] code_o
);

   generate
      if (W != uart_irq_pkg::CODE_W) begin : g_bad_w
         $error("uart_irq_prio: W must equal CODE_W");
      end
      if (N != uart_irq_pkg::NUM_SRC) begin : g_bad_n
         $error("uart_irq_prio: N must equal NUM_SRC");
      end
   endgenerate

   always_comb begin
      logic seen;
      logic [W-1:0] acc;
      seen  = 1'b0;
      acc   = uart_irq_pkg::CODE_NONE;
      sel_o = '0;
      for (int i = 0; i < N; i++) begin
         if (pend_i[i] && !seen) begin
            sel_o[i] = 1'b1;
            acc      = uart_irq_pkg::src_code(i);
         end
         seen = seen | pend_i[i];
      end
      any_o  = seen;
      code_o = acc;
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
   parameter int EN_W           = 6,
   parameter int FLOW_PINS      = 2,
   parameter int MODE_BITS      = 4,
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EN_W-1:0]      en_i,
   input  logic [FLOW_PINS-1:0] flow_pins_n_i,
   input  logic                 rx_err_lvl_i,
   input  logic                 rx_trig_lvl_i,
   input  logic                 ovr_evt_i,
   input  logic                 tmo_evt_i,
   input  logic                 txh_evt_i,
   input  logic                 msr_evt_i,
   input  logic                 xoff_evt_i,
   input  logic                 xon_evt_i,
   input  logic                 spec_evt_i,
   input  logic                 lsr_rd_i,
   input  logic                 rhr_rd_i,
   input  logic                 thr_wr_i,
   input  logic                 msr_rd_i,
   input  logic                 id_rd_i,
   output logic                 irq_o,
   output logic [5:0]           id_code_o
);

   import uart_irq_pkg::*;

   localparam int NSRC  = NUM_SRC;
   localparam int NFLAG = 7;
   // latched flag positions
   localparam int F_OVR = 0;
   localparam int F_TMO = 1;
   localparam int F_THR = 2;
   localparam int F_MSR = 3;
   localparam int F_XOF = 4;
   localparam int F_SPC = 5;
   localparam int F_FLW = 6;

   generate
      if (EN_W != 6) begin : g_bad_en
         $error("uart_irq_ident: EN_W must be 6");
      end
      if (MODE_BITS < 1 || MODE_BITS > EN_W) begin : g_bad_mode
         $error("uart_irq_ident: MODE_BITS out of range");
      end
      if (FLOW_PINS < 1) begin : g_bad_flow
         $error("uart_irq_ident: FLOW_PINS must be at least 1");
      end
   endgenerate

   logic             flow_rise;
   logic [NFLAG-1:0] f_set, f_clr, f_q;
   logic [NSRC-1:0]  raw, pend, sel, id_hit;
   logic             any_pend;
   logic [CODE_W-1:0] code;

   uart_irq_edge #(.N(FLOW_PINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_n_i (flow_pins_n_i),
      .rise_o   (flow_rise)
   );

   // an ID read clears only what it returned
   assign id_hit = sel & {NSRC{id_rd_i}};

   always_comb begin
      f_set        = '0;
      f_clr        = '0;
      f_set[F_OVR] = ovr_evt_i;   f_clr[F_OVR] = lsr_rd_i;
      f_set[F_TMO] = tmo_evt_i;   f_clr[F_TMO] = rhr_rd_i;
      f_set[F_THR] = txh_evt_i;   f_clr[F_THR] = thr_wr_i | id_hit[SLOT_THR];
      f_set[F_MSR] = msr_evt_i;   f_clr[F_MSR] = msr_rd_i;
      f_set[F_XOF] = xoff_evt_i;  f_clr[F_XOF] = xon_evt_i;
      f_set[F_SPC] = spec_evt_i;  f_clr[F_SPC] = id_hit[SLOT_XOF];
      f_set[F_FLW] = flow_rise;   f_clr[F_FLW] = id_hit[SLOT_FLW];
   end

   generate
      for (genvar g = 0; g < NFLAG; g++) begin : g_flag
         uart_irq_flag #(.SET_WINS(SET_OVER_CLEAR)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (f_set[g]),
            .clr_i  (f_clr[g]),
            .flag_o (f_q[g])
         );
      end
   endgenerate

   always_comb begin
      raw           = '0;
      raw[SLOT_LSR] = f_q[F_OVR] | rx_err_lvl_i;
      raw[SLOT_TMO] = f_q[F_TMO];
      raw[SLOT_RXD] = rx_trig_lvl_i;
      raw[SLOT_THR] = f_q[F_THR];
      raw[SLOT_MSR] = f_q[F_MSR];
      raw[SLOT_XOF] = f_q[F_XOF] | f_q[F_SPC];
      raw[SLOT_FLW] = f_q[F_FLW];
   end

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_mask
         localparam int EB = src_en_bit(s);
         assign pend[s] = raw[s] & en_i[EB];
      end
   endgenerate

   uart_irq_prio #(.N(NSRC), .W(CODE_W)) u_prio (
      .pend_i (pend),
      .sel_o  (sel),
      .any_o  (any_pend),
      .code_o (code)
   );

   assign id_code_o = code;
   assign irq_o     = any_pend & (|en_i[MODE_BITS-1:0]);

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
   parameter int EN_W      = 6,
   parameter int FLOW_PINS = 2,
   parameter int MODE_BITS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [EN_W-1:0]      en_i,
   input logic [FLOW_PINS-1:0] flow_pins_n_i,
   input logic                 rx_err_lvl_i,
   input logic                 ovr_evt_i,
   input logic                 tmo_evt_i,
   input logic                 irq_o,
   input logic [5:0]           id_code_o
);

   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assert_req_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !id_code_o[0]);

   assert_legal_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (id_code_o == 6'b000001 || id_code_o == 6'b000110 || id_code_o == 6'b001100 ||
       id_code_o == 6'b000100 || id_code_o == 6'b000010 || id_code_o == 6'b000000 ||
       id_code_o == 6'b010000 || id_code_o == 6'b100000));

   assert_polled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[MODE_BITS-1:0] == '0) |-> !irq_o);

   assert_err_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[2] && rx_err_lvl_i) |-> id_code_o == 6'b000110);

   assert_ovr_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt_i |=> (!en_i[2] || id_code_o == 6'b000110));

   assert_tmo_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt_i |=> (!en_i[0] || id_code_o == 6'b001100 || id_code_o == 6'b000110));

   assert_all_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0) |-> (id_code_o == 6'b000001 && !irq_o));

   assert_flow_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && |(flow_pins_n_i & ~$past(flow_pins_n_i))) |=>
         (!en_i[5] || id_code_o != 6'b000001));

endmodule

bind uart_irq_ident uart_irq_chk #(
   .EN_W(EN_W), .FLOW_PINS(FLOW_PINS), .MODE_BITS(MODE_BITS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en_i          (en_i),
   .flow_pins_n_i (flow_pins_n_i),
   .rx_err_lvl_i  (rx_err_lvl_i),
   .ovr_evt_i     (ovr_evt_i),
   .tmo_evt_i     (tmo_evt_i),
   .irq_o         (irq_o),
   .id_code_o     (id_code_o)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] en;
   logic [1:0] pins_n;
   logic       rx_err, rx_trig;
   logic       ovr, tmo, txh, msr, xoff, xon, spec;
   logic       lsr_rd, rhr_rd, thr_wr, msr_rd, id_rd;
   logic       irq;
   logic [5:0] code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   uart_irq_ident uut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .flow_pins_n_i(pins_n),
      .rx_err_lvl_i(rx_err), .rx_trig_lvl_i(rx_trig),
      .ovr_evt_i(ovr), .tmo_evt_i(tmo), .txh_evt_i(txh), .msr_evt_i(msr),
      .xoff_evt_i(xoff), .xon_evt_i(xon), .spec_evt_i(spec),
      .lsr_rd_i(lsr_rd), .rhr_rd_i(rhr_rd), .thr_wr_i(thr_wr),
      .msr_rd_i(msr_rd), .id_rd_i(id_rd),
      .irq_o(irq), .id_code_o(code)
   );

   // en(6) {cts_n,rts_n}(2) {err,trig}(2) {ovr,tmo,txh,msr,xoff,xon,spec}(7)
   // {lsr,rhr,thrwr,msrrd,idrd}(5) exp_code(6) exp_irq(1)
   localparam int NV = 33;
   localparam logic [28:0] VEC [NV] = '{
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0010000, 5'b00000, 6'b000010, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0001000, 5'b00000, 6'b000010, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b000000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00010, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0100000, 5'b00000, 6'b001100, 1'b1},
      {6'b111111, 2'b11, 2'b01, 7'b0000000, 5'b00000, 6'b001100, 1'b1},
      {6'b111111, 2'b11, 2'b01, 7'b0000000, 5'b01000, 6'b000100, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b1000000, 5'b00000, 6'b000110, 1'b1},
      {6'b111111, 2'b11, 2'b10, 7'b0000000, 5'b10000, 6'b000110, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0000100, 5'b00000, 6'b010000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b010000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000010, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0000001, 5'b00000, 6'b010000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000010, 5'b00000, 6'b010000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b000001, 1'b0},
      {6'b111111, 2'b01, 2'b00, 7'b0000000, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b100000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0010000, 5'b00000, 6'b000010, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00100, 6'b100000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b000001, 1'b0},
      {6'b110000, 2'b10, 2'b00, 7'b0000000, 5'b00000, 6'b000001, 1'b0},
      {6'b110000, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b100000, 1'b0},
      {6'b110000, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b000001, 1'b0},
      {6'b111011, 2'b11, 2'b00, 7'b1000000, 5'b00000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00000, 6'b000110, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b10000, 6'b000001, 1'b0},
      {6'b111111, 2'b11, 2'b00, 7'b0011000, 5'b00000, 6'b000010, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0010000, 5'b00100, 6'b000010, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00001, 6'b000000, 1'b1},
      {6'b111111, 2'b11, 2'b00, 7'b0000000, 5'b00010, 6'b000001, 1'b0}
   };

   function automatic string tag_of(int i);
      case (i)
         0:                 return "R1";
         1, 20, 21:         return "R5";
         2, 3:              return "R9";
         4, 31, 32:         return "R6";
         5, 6:              return "R3";
         7, 8:              return "R4";
         9, 10, 11:         return "R2";
         12, 13, 14, 15, 16, 17: return "R7";
         18, 19, 22:        return "R8";
         23, 24, 25:        return "R11";
         26, 27, 28:        return "R10";
         29:                return "R13";
         default:           return "R12";
      endcase
   endfunction

   task automatic idle_inputs();
      {ovr, tmo, txh, msr, xoff, xon, spec} = '0;
      {lsr_rd, rhr_rd, thr_wr, msr_rd, id_rd} = '0;
   endtask

   task automatic check(logic [5:0] exp_code, logic exp_irq, string req);
      checks++;
      if (code !== exp_code || irq !== exp_irq) begin
         fails++;
         $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                  req, code, irq, exp_code, exp_irq);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      en = 6'b111111; pins_n = 2'b11; rx_err = 1'b0; rx_trig = 1'b0;
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check(6'b000001, 1'b0, "R1");   // reset state

      // table walk
      for (int i = 0; i < NV; i++) begin
         en     = VEC[i][28:23];
         pins_n = {VEC[i][21], VEC[i][22]};   // bit0 cts_n, bit1 rts_n
         {rx_err, rx_trig} = VEC[i][20:19];
         {ovr, tmo, txh, msr, xoff, xon, spec} = VEC[i][18:12];
         {lsr_rd, rhr_rd, thr_wr, msr_rd, id_rd} = VEC[i][11:7];
         step();
         check(VEC[i][6:1], VEC[i][0], tag_of(i));
      end
      idle_inputs();
      en = 6'b111111; pins_n = 2'b11; rx_err = 1'b0; rx_trig = 1'b0;

      // R13: error level shows in the same cycle, no edge needed
      rx_err = 1'b1; #1;
      check(6'b000110, 1'b1, "R13");
      rx_err = 1'b0; #1;
      check(6'b000001, 1'b0, "R13");

      // R7/R9: both Xoff and special pending; ID read clears special only
      xoff = 1'b1; spec = 1'b1; step(); idle_inputs();
      check(6'b010000, 1'b1, "R7");
      id_rd = 1'b1; step(); idle_inputs();
      check(6'b010000, 1'b1, "R9");
      xon = 1'b1; step(); idle_inputs();
      check(6'b000001, 1'b0, "R7");

      // R8: request-to-send pin rising
      pins_n = 2'b01; step();
      check(6'b000001, 1'b0, "R8");
      pins_n = 2'b11; step();
      check(6'b100000, 1'b1, "R8");

      // R1: reset drops a pending flag
      txh = 1'b1; step(); idle_inputs();
      rst_n = 1'b0; step();
      rst_n = 1'b1; step();
      check(6'b000001, 1'b0, "R1");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule